// File: doc/BRIEF.md
# Trigger-Latency Pipeline and Event Derandomiser

This block keeps the 96-bit hit pattern of every beam crossing for as long as the first-level trigger needs to decide on it. A 64-entry circular pipeline takes one pattern on every beam clock. A 16-bit crossing counter runs next to it. When an accept pulse arrives, a programmable latency picks the crossing that lies that many clocks in the past. That pattern, together with its crossing number, is copied into a five-event buffer.

The crate controller empties the buffer one 16-bit word at a time. Each event gives seven words: six slices of the pattern, then the crossing number. A full buffer asserts a busy output. Accepts that arrive while the buffer is full are dropped and raise a sticky overflow flag. Reads and accepts may fall in the same clock.

Top module: `trig_latency_buffer`

## Requirements
- R1: While reset is held and in the cycle after it is released, `rdValid`, `busy` and `overflow` are 0.
- R2: An accept sampled in a cycle with `latency` = L (0..63) captures the pattern that was presented L clocks earlier. L = 0 captures the pattern presented in the same cycle.
- R3: A 16-bit crossing number starts at 0 for the first crossing after reset, rises by one per clock and wraps. Each captured event stores the number of its selected crossing.
- R4: The seven words of an event come out in this order: word k (k = 0..5) is pattern bits [16k+15:16k], and word 6 is the crossing number.
- R5: `rdEn` sampled while the buffer holds an event yields `rdValid` = 1 with its word on `rdData` one clock later. `rdEn` with an empty buffer yields `rdValid` = 0 and changes nothing.
- R6: Events leave in the order they were accepted, and up to five are held.
- R7: `busy` is 1 exactly while five events are held. An accept sampled while `busy` is 1 is discarded and sets `overflow`, which stays 1 until reset.
- R8: An accept and a read in the same clock both take effect, and no stored word is corrupted.
- R9: Reading may pause at any word. The next read continues with the following word of the same event.
- R10: An event is removed after its seventh word is read. Reading the last word of the head event while full clears `busy` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beam clock, one crossing per rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| hitPattern | input | 96 | Hit pattern of the current crossing |
| l1Accept | input | 1 | Trigger accept for the crossing `latency` clocks back |
| latency | input | 6 | Trigger latency in crossings |
| rdEn | input | 1 | Request for the next 16-bit word |
| rdData | output | 16 | Read word, valid while `rdValid` is 1 |
| rdValid | output | 1 | Marks the word answering the previous clock's `rdEn` |
| busy | output | 1 | Event buffer full |
| overflow | output | 1 | Sticky flag: an accept was lost |

## Verification
A wrong pipeline pointer or latency subtraction shows up in the first word of the next event that is read out. The effect is seen only at readout, so it can appear many clocks after the faulty capture. A crossing counter that is off or fails to wrap appears as a bad seventh word once an accepted crossing lies past the fault. A miscounted occupancy or misplaced buffer index shows at the ports within one clock, through `busy` or `overflow`. It can also appear later as events out of order or duplicated. The stimulus fills the buffer, pauses reads within an event, reads and accepts together, and runs past the counter wrap.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int HIT_W      = 96;
  parameter int PIPE_DEPTH = 64;
  parameter int WORD_W     = 16;
  parameter int BX_W       = 16;
  parameter int EV_DEPTH   = 5;

  localparam int LAT_W        = $clog2(PIPE_DEPTH);
  localparam int DATA_WORDS   = HIT_W / WORD_W;
  localparam int WORDS_PER_EV = DATA_WORDS + 1;
  localparam int EV_IDX_W     = $clog2(EV_DEPTH);
  localparam int EV_CNT_W     = $clog2(EV_DEPTH + 1);
  localparam int WSEL_W       = $clog2(WORDS_PER_EV);

  typedef struct packed {
    logic                push;
    logic [EV_IDX_W-1:0] wrIdx;
    logic                rdFire;
    logic [EV_IDX_W-1:0] rdIdx;
    logic [WSEL_W-1:0]   wordSel;
  } tlbStrobes_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        l1Accept,
  input  logic        rdEn,
  output tlbStrobes_t strobes,
  output logic        busy,
  output logic        overflow
);
  localparam logic [EV_CNT_W-1:0] CNT_FULL  = EV_CNT_W'(EV_DEPTH);
  localparam logic [EV_IDX_W-1:0] IDX_LAST  = EV_IDX_W'(EV_DEPTH - 1);
  localparam logic [WSEL_W-1:0]   WORD_LAST = WSEL_W'(WORDS_PER_EV - 1);

  logic [EV_CNT_W-1:0] evCount;
  logic [EV_IDX_W-1:0] wrIdx, rdIdx;
  logic [WSEL_W-1:0]   wordSel;
  logic                full, empty, push, rdFire, pop;

  function automatic logic [EV_IDX_W-1:0] nextIdx(input logic [EV_IDX_W-1:0] i);
    return (i == IDX_LAST) ? '0 : i + 1'b1;
  endfunction

  assign full   = (evCount == CNT_FULL);
  assign empty  = (evCount == '0);
  assign push   = l1Accept && !full;
  assign rdFire = rdEn && !empty;
  assign pop    = rdFire && (wordSel == WORD_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evCount  <= '0;
      wrIdx    <= '0;
      rdIdx    <= '0;
      wordSel  <= '0;
      overflow <= 1'b0;
    end else begin
      if (push)   wrIdx <= nextIdx(wrIdx);
      if (pop)    rdIdx <= nextIdx(rdIdx);
      if (rdFire) wordSel <= pop ? '0 : wordSel + 1'b1;
      case ({push, pop})
        2'b10:   evCount <= evCount + 1'b1;
        2'b01:   evCount <= evCount - 1'b1;
        default: evCount <= evCount;
      endcase
      if (l1Accept && full) overflow <= 1'b1;
    end
  end

  assign busy = full;
  always_comb begin
    strobes.push    = push;
    strobes.wrIdx   = wrIdx;
    strobes.rdFire  = rdFire;
    strobes.rdIdx   = rdIdx;
    strobes.wordSel = wordSel;
  end

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    evCount <= CNT_FULL);
  p_drop_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (l1Accept && busy) |=> overflow);
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
  p_full_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !rdEn) |=> busy);
  p_last_word_frees_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rdEn && wordSel == WORD_LAST) |=> !busy);
  p_same_clock_r8: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop) |=> $stable(evCount));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HIT_W-1:0]  hitPattern,
  input  logic [LAT_W-1:0]  latency,
  input  tlbStrobes_t       strobes,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [HIT_W-1:0]  pipeMem [PIPE_DEPTH];
  logic [LAT_W-1:0]  pipeWrPtr, pipeRdPtr;
  logic [BX_W-1:0]   bxCount, selBx;
  logic [HIT_W-1:0]  selHit;
  logic [HIT_W-1:0]  evHit [EV_DEPTH];
  logic [BX_W-1:0]   evBx  [EV_DEPTH];
  logic [WORD_W-1:0] wordArr [WORDS_PER_EV];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pipeWrPtr <= '0;
      bxCount   <= '0;
    end else begin
      pipeWrPtr <= pipeWrPtr + 1'b1;
      bxCount   <= bxCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    pipeMem[pipeWrPtr] <= hitPattern;
  end

  assign pipeRdPtr = pipeWrPtr - latency;
  assign selHit    = (latency == '0) ? hitPattern : pipeMem[pipeRdPtr];
  assign selBx     = bxCount - BX_W'(latency);

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      evHit[strobes.wrIdx] <= selHit;
      evBx[strobes.wrIdx]  <= selBx;
    end
  end

  for (genvar w = 0; w < WORDS_PER_EV; w++) begin : g_word
    if (w < DATA_WORDS) begin : g_slice
      assign wordArr[w] = evHit[strobes.rdIdx][w*WORD_W +: WORD_W];
    end else begin : g_count
      assign wordArr[w] = evBx[strobes.rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdFire;
      if (strobes.rdFire) rdData <= wordArr[strobes.wordSel];
    end
  end

  p_crossing_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (bxCount == $past(bxCount) + BX_W'(1)));
  p_valid_needs_fire_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strobes.rdFire));
endmodule

// File: rtl/trig_latency_buffer.sv
module trig_latency_buffer
  import tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [HIT_W-1:0]  hitPattern,
  input  logic              l1Accept,
  input  logic [LAT_W-1:0]  latency,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid,
  output logic              busy,
  output logic              overflow
);
  tlbStrobes_t strobes;

  tlb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .l1Accept (l1Accept),
    .rdEn     (rdEn),
    .strobes  (strobes),
    .busy     (busy),
    .overflow (overflow)
  );

  tlb_datapath u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .hitPattern (hitPattern),
    .latency    (latency),
    .strobes    (strobes),
    .rdData     (rdData),
    .rdValid    (rdValid)
  );

  p_valid_after_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!busy && !overflow));
endmodule

// File: tb/trig_latency_buffer_bench.sv
module trig_latency_buffer_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [95:0] hitPattern;
  logic        l1Accept;
  logic [5:0]  latency;
  logic        rdEn;
  logic [15:0] rdData;
  logic        rdValid, busy, overflow;

  always #10 clk = ~clk;

  trig_latency_buffer u_trig_latency_buffer (
    .clk(clk), .rstN(rstN), .hitPattern(hitPattern), .l1Accept(l1Accept),
    .latency(latency), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .overflow(overflow)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  logic [95:0] hist [256];
  logic [95:0] qHit [$];
  logic [15:0] qBx  [$];
  int  mSel = 0;
  bit  mOvf = 0;

  function automatic logic [15:0] wordOf(input logic [95:0] h, input logic [15:0] bx, input int sel);
    return (sel == 6) ? bx : h[sel*16 +: 16];
  endfunction

  function automatic logic [95:0] rndHit();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at crossing %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  task automatic step(input logic [95:0] hit, input logic acc, input logic [5:0] lat,
                      input logic rd, input string tag);
    bit expValid = 0;
    bit doPop = 0;
    logic [15:0] expData = '0;
    int sizeBefore = qHit.size();
    hitPattern = hit; l1Accept = acc; latency = lat; rdEn = rd;
    hist[cyc % 256] = hit;
    if (rd && sizeBefore > 0) begin
      expValid = 1;
      expData = wordOf(qHit[0], qBx[0], mSel);
      if (mSel == 6) begin mSel = 0; doPop = 1; end else mSel++;
    end
    if (acc) begin
      if (sizeBefore < 5) begin
        qHit.push_back(hist[(cyc - lat) % 256]);
        qBx.push_back(16'(cyc - lat));
      end else mOvf = 1;
    end
    if (doPop) begin void'(qHit.pop_front()); void'(qBx.pop_front()); end
    @(posedge clk); cyc++; @(negedge clk);
    chk(rdValid == expValid, {tag, " R5 valid"}, 96'(rdValid), 96'(expValid));
    if (expValid) chk(rdData == expData, {tag, " R4 word"}, 96'(rdData), 96'(expData));
    chk(busy == (qHit.size() == 5), {tag, " R7 busy"}, 96'(busy), 96'(qHit.size() == 5));
    chk(overflow == mOvf, {tag, " R7 overflow"}, 96'(overflow), 96'(mOvf));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 0; hitPattern = '0; l1Accept = 0; latency = '0; rdEn = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!rdValid && !busy && !overflow, "R1 reset", {rdValid, busy, overflow}, 0);
    rstN = 1;
    // R2: zero latency captures the same crossing
    step(96'hA5A5_0001_0002_0003_0004_0005, 1, 6'd0, 0, "R2 lat0");
    for (int i = 0; i < 7; i++) step(rndHit(), 0, 6'd0, 1, "R2 R4 read lat0");
    // R2: maximum latency 63
    for (int i = 0; i < 70; i++) step(rndHit(), 0, 6'd63, 0, "R2 fill");
    step(rndHit(), 1, 6'd63, 0, "R2 lat63");
    for (int i = 0; i < 7; i++) step(rndHit(), 0, 6'd63, 1, "R2 R3 read lat63");
    // R7: six accepts without reads, last one dropped
    for (int i = 0; i < 6; i++) step(rndHit(), 1, 6'd5, 0, "R7 fill");
    step(rndHit(), 1, 6'd9, 0, "R7 drop again");
    // R9: pause inside an event; R10 busy clears after last word
    for (int i = 0; i < 3; i++) step(rndHit(), 0, 6'd5, 1, "R9 first words");
    for (int i = 0; i < 2; i++) step(rndHit(), 0, 6'd5, 0, "R9 pause");
    for (int i = 0; i < 4; i++) step(rndHit(), 0, 6'd5, 1, "R9 R10 resume");
    // R8: accept and read in the same clock
    for (int i = 0; i < 10; i++) step(rndHit(), 1, 6'd12, 1, "R8 same clock");
    // R5 R6: drain, then read an empty buffer
    for (int i = 0; i < 50; i++) step(rndHit(), 0, 6'd12, 1, "R6 drain");
    for (int i = 0; i < 3; i++) step(rndHit(), 0, 6'd12, 1, "R5 empty read");
    // Random traffic past the crossing-counter wrap (R3), mixed latencies (R2)
    for (int blk = 0; blk < 700; blk++) begin
      logic [5:0] lat = 6'($urandom_range(0, 63));
      int rdPct = (blk % 3 == 0) ? 20 : 60;
      for (int i = 0; i < 100; i++) begin
        logic acc = ($urandom_range(0, 99) < 25) && (cyc >= lat);
        logic rd  = ($urandom_range(0, 99) < rdPct);
        step(rndHit(), acc, lat, rd, "R3 R6 random");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule